// File: doc/BRIEF.md
# Configurable Register Cell for a Sum-of-Products Array

This block sits behind the OR plane of a programmable AND-OR array. It takes a bundle of four sum terms and uses them as the data and control inputs of a single storage bit. A static mode field sets the storage bit's behaviour. It can act as a data flip-flop, a toggle flip-flop or a JK flip-flop. One sum term serves as a clock enable for the cell, and another is passed straight through as the combinational result.

Two independent selectors choose what leaves the cell. The first picks the value driven toward the output pin. The second picks the value returned to the AND plane as a new literal. Each selector chooses between the stored bit and the combinational term. A global clear and a global preset force the stored bit whatever the sum terms carry. Clear wins when both are raised.

Top module: `lcell_top`

## Requirements
- R1: When `gbl_clr` is high at a rising clock edge, the stored bit becomes 0, whatever the values of `gbl_set`, `mode_cfg` and `sum_in`.
- R2: When `gbl_set` is high and `gbl_clr` is low at a rising edge, the stored bit becomes 1, whatever the value of `sum_in`.
- R3: When both `gbl_clr` and `gbl_set` are high at the same edge, the stored bit becomes 0.
- R4: With `mode_cfg` = 2'b00 (data mode), `sum_in[2]` = 1 and neither global control high, the stored bit takes `sum_in[0]` at the edge.
- R5: With `mode_cfg` = 2'b01 (toggle mode) and `sum_in[2]` = 1, the stored bit inverts when `sum_in[0]` = 1 and is kept when `sum_in[0]` = 0.
- R6: With `mode_cfg` = 2'b10 (JK mode) and `sum_in[2]` = 1, J is `sum_in[0]` and K is `sum_in[1]`. The values J=0,K=0 keep the bit. J=1,K=0 set it. J=0,K=1 clear it. J=1,K=1 invert it on every edge.
- R7: With `sum_in[2]` = 0 and neither global control high, the stored bit keeps its value in every mode.
- R8: `pin_o` equals the stored bit when `pin_sel` = 1 and equals `sum_in[3]` when `pin_sel` = 0. `fb_o` follows the same rule with `fb_sel`, and the two selectors do not affect each other.
- R9: `mode_cfg` = 2'b11 behaves exactly as data mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the stored bit updates on its rising edge |
| gbl_clr | input | 1 | Global clear, active high, synchronous, highest priority |
| gbl_set | input | 1 | Global preset, active high, synchronous |
| mode_cfg | input | 2 | Storage kind: 00 data, 01 toggle, 10 JK, 11 data |
| pin_sel | input | 1 | Pin path source: 1 stored bit, 0 combinational term |
| fb_sel | input | 1 | Feedback path source: 1 stored bit, 0 combinational term |
| sum_in | input | 4 | Sum terms: [0] D/T/J, [1] K, [2] clock enable, [3] combinational term |
| pin_o | output | 1 | Value toward the output pin |
| fb_o | output | 1 | Value returned to the AND plane |

## Verification
The assertions check on every cycle that clear and preset force the stored bit with clear winning, that a low enable freezes it, that data and JK-toggle updates land one edge later, and that both output selectors track their chosen source. The bench's reference model covers the cases the properties do not isolate. These are every JK input pair in sequence, toggle chains across many edges, the aliasing of the spare mode code onto data mode, and long pseudo-random streams of sum terms in every mode with the selectors set independently.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  typedef enum logic [1:0] {
    KIND_D   = 2'b00,
    KIND_T   = 2'b01,
    KIND_JK  = 2'b10,
    KIND_DX  = 2'b11
  } reg_kind_e;
endpackage

// File: rtl/lcell_next.sv
module lcell_next
  import lcell_pkg::*;
(
  input  reg_kind_e kind,
  input  logic      cur_q,
  input  logic      a_term,
  input  logic      b_term,
  output logic      nxt_q
);
  always_comb begin
    unique case (kind)
      KIND_T:  nxt_q = cur_q ^ a_term;
      KIND_JK: nxt_q = (a_term & ~cur_q) | (~b_term & cur_q);
      default: nxt_q = a_term;
    endcase
  end
endmodule

// File: rtl/lcell_store.sv
module lcell_store #(
  parameter logic INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic set,
  input  logic en,
  input  logic nxt,
  output logic q
);
  logic q_r = INIT_VAL;

  always_ff @(posedge clk) begin
    if (clr)      q_r <= 1'b0;
    else if (set) q_r <= 1'b1;
    else if (en)  q_r <= nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/lcell_route.sv
module lcell_route #(
  parameter int N_PATHS = 2
) (
  input  logic [N_PATHS-1:0] sel,
  input  logic               reg_v,
  input  logic               comb_v,
  output logic [N_PATHS-1:0] out
);
  for (genvar g = 0; g < N_PATHS; g++) begin : g_path
    assign out[g] = sel[g] ? reg_v : comb_v;
  end
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int TERMS    = 4,
  parameter int A_IDX    = 0,
  parameter int B_IDX    = 1,
  parameter int EN_IDX   = 2,
  parameter int COMB_IDX = 3
) (
  input  logic             clk,
  input  logic             gbl_clr,
  input  logic             gbl_set,
  input  logic [1:0]       mode_cfg,
  input  logic             pin_sel,
  input  logic             fb_sel,
  input  logic [TERMS-1:0] sum_in,
  output logic             pin_o,
  output logic             fb_o
);
  localparam int N_PATHS = 2;

  reg_kind_e          kind;
  logic               q_r;
  logic               nxt_q;
  logic [N_PATHS-1:0] route_sel;
  logic [N_PATHS-1:0] route_out;

  assign kind = reg_kind_e'(mode_cfg);

  lcell_next u_next (
    .kind   (kind),
    .cur_q  (q_r),
    .a_term (sum_in[A_IDX]),
    .b_term (sum_in[B_IDX]),
    .nxt_q  (nxt_q)
  );

  lcell_store #(.INIT_VAL(1'b0)) u_store (
    .clk (clk),
    .clr (gbl_clr),
    .set (gbl_set),
    .en  (sum_in[EN_IDX]),
    .nxt (nxt_q),
    .q   (q_r)
  );

  assign route_sel = {fb_sel, pin_sel};

  lcell_route #(.N_PATHS(N_PATHS)) u_route (
    .sel    (route_sel),
    .reg_v  (q_r),
    .comb_v (sum_in[COMB_IDX]),
    .out    (route_out)
  );

  assign pin_o = route_out[0];
  assign fb_o  = route_out[1];
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk #(
  parameter int TERMS = 4
) (
  input logic             clk,
  input logic             gbl_clr,
  input logic             gbl_set,
  input logic [1:0]       mode_cfg,
  input logic             pin_sel,
  input logic             fb_sel,
  input logic [TERMS-1:0] sum_in,
  input logic             q,
  input logic             pin_o,
  input logic             fb_o
);
  p_clr_r1: assert property (@(posedge clk) gbl_clr |=> !q);

  p_set_r2: assert property (@(posedge clk) disable iff (gbl_clr)
    gbl_set |=> q);

  p_both_r3: assert property (@(posedge clk)
    (gbl_clr && gbl_set) |=> !q);

  p_data_r4: assert property (@(posedge clk) disable iff (gbl_clr || gbl_set)
    (mode_cfg == 2'b00 && sum_in[2]) |=> (q == $past(sum_in[0])));

  p_jk_flip_r6: assert property (@(posedge clk) disable iff (gbl_clr || gbl_set)
    (mode_cfg == 2'b10 && sum_in[2] && sum_in[0] && sum_in[1]) |=> (q != $past(q)));

  p_hold_r7: assert property (@(posedge clk) disable iff (gbl_clr || gbl_set)
    !sum_in[2] |=> $stable(q));

  p_pin_r8: assert property (@(posedge clk) disable iff (gbl_clr)
    pin_o == (pin_sel ? q : sum_in[3]));

  p_fb_r8: assert property (@(posedge clk) disable iff (gbl_clr)
    fb_o == (fb_sel ? q : sum_in[3]));
endmodule

bind lcell_top lcell_chk #(.TERMS(TERMS)) u_chk (
  .clk      (clk),
  .gbl_clr  (gbl_clr),
  .gbl_set  (gbl_set),
  .mode_cfg (mode_cfg),
  .pin_sel  (pin_sel),
  .fb_sel   (fb_sel),
  .sum_in   (sum_in),
  .q        (q_r),
  .pin_o    (pin_o),
  .fb_o     (fb_o)
);

// File: tb/sim_lcell_top.sv
`timescale 1ns/1ps
module sim_lcell_top;
  logic       clk = 1'b0;
  logic       gbl_clr = 1'b1;
  logic       gbl_set = 1'b0;
  logic [1:0] mode_cfg = 2'b00;
  logic       pin_sel = 1'b1;
  logic       fb_sel = 1'b1;
  logic [3:0] sum_in = 4'b0000;
  logic       pin_o, fb_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R1";
  logic m_q = 1'b0;

  always #4 clk = ~clk;

  lcell_top u0 (
    .clk(clk), .gbl_clr(gbl_clr), .gbl_set(gbl_set), .mode_cfg(mode_cfg),
    .pin_sel(pin_sel), .fb_sel(fb_sel), .sum_in(sum_in),
    .pin_o(pin_o), .fb_o(fb_o)
  );

  // behavioural reference of the stored bit
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (gbl_clr) m_q <= 1'b0;
    else if (gbl_set) m_q <= 1'b1;
    else if (sum_in[2]) begin
      case (mode_cfg)
        2'b01: m_q <= m_q ^ sum_in[0];
        2'b10: begin
          if (sum_in[0] && sum_in[1]) m_q <= ~m_q;
          else if (sum_in[0]) m_q <= 1'b1;
          else if (sum_in[1]) m_q <= 1'b0;
        end
        default: m_q <= sum_in[0];
      endcase
    end
  end

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare();
    check_bit(tag, "pin_o", pin_o, pin_sel ? m_q : sum_in[3]);
    check_bit(tag, "fb_o", fb_o, fb_sel ? m_q : sum_in[3]);
  endtask

  // one edge, then compare at the falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    tag = "R1"; gbl_set = 1'b1; sum_in = 4'b1111; mode_cfg = 2'b10;
    cyc(); cyc();
    check_bit("R1", "pin_o reset", pin_o, 1'b0);
    gbl_clr = 1'b0; gbl_set = 1'b0; sum_in = 4'b0000;
    // R2: preset
    tag = "R2"; gbl_set = 1'b1; sum_in = 4'b0100;
    cyc();
    check_bit("R2", "pin_o preset", pin_o, 1'b1);
    gbl_set = 1'b0;
    // R3: both high
    tag = "R3"; gbl_clr = 1'b1; gbl_set = 1'b1;
    cyc();
    check_bit("R3", "pin_o both", pin_o, 1'b0);
    gbl_clr = 1'b0; gbl_set = 1'b0;
    // R4: data mode
    tag = "R4"; mode_cfg = 2'b00;
    sum_in = 4'b0101; cyc(); check_bit("R4", "d=1", pin_o, 1'b1);
    sum_in = 4'b0100; cyc(); check_bit("R4", "d=0", pin_o, 1'b0);
    sum_in = 4'b0101; cyc();
    // R7: hold in data mode
    tag = "R7"; sum_in = 4'b0000; cyc(); cyc();
    check_bit("R7", "hold d", pin_o, 1'b1);
    // R5: toggle mode
    tag = "R5"; mode_cfg = 2'b01;
    sum_in = 4'b0101; cyc(); check_bit("R5", "t flip", pin_o, 1'b0);
    cyc(); check_bit("R5", "t flip2", pin_o, 1'b1);
    sum_in = 4'b0100; cyc(); check_bit("R5", "t keep", pin_o, 1'b1);
    tag = "R7"; sum_in = 4'b0001; cyc(); check_bit("R7", "hold t", pin_o, 1'b1);
    // R6: JK mode, all pairs
    tag = "R6"; mode_cfg = 2'b10;
    sum_in = 4'b0110; cyc(); check_bit("R6", "k clear", pin_o, 1'b0);
    sum_in = 4'b0100; cyc(); check_bit("R6", "jk hold", pin_o, 1'b0);
    sum_in = 4'b0101; cyc(); check_bit("R6", "j set", pin_o, 1'b1);
    sum_in = 4'b0111; cyc(); check_bit("R6", "jk flip a", pin_o, 1'b0);
    cyc(); check_bit("R6", "jk flip b", pin_o, 1'b1);
    cyc(); check_bit("R6", "jk flip c", pin_o, 1'b0);
    tag = "R7"; sum_in = 4'b0011; cyc(); check_bit("R7", "hold jk", pin_o, 1'b0);
    // R9: spare code behaves as data
    tag = "R9"; mode_cfg = 2'b11;
    sum_in = 4'b0101; cyc(); check_bit("R9", "dx=1", pin_o, 1'b1);
    sum_in = 4'b0110; cyc(); check_bit("R9", "dx=0", pin_o, 1'b0);
    // R8: selectors independent
    tag = "R8"; pin_sel = 1'b0; fb_sel = 1'b1; sum_in = 4'b1000;
    cyc();
    check_bit("R8", "pin comb", pin_o, 1'b1);
    check_bit("R8", "fb reg", fb_o, 1'b0);
    pin_sel = 1'b1; fb_sel = 1'b0;
    cyc();
    check_bit("R8", "pin reg", pin_o, 1'b0);
    check_bit("R8", "fb comb", fb_o, 1'b1);
    // mixed pseudo-random stream across every mode
    begin
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        mode_cfg = 2'(i / 100);
        tag = (i < 100) ? "R4" : (i < 200) ? "R5" : (i < 300) ? "R6" : "R9";
        sum_in = lf[3:0];
        pin_sel = lf[4];
        fb_sel = lf[5];
        gbl_set = (lf == 8'h3C);
        gbl_clr = (lf == 8'h71);
        if (gbl_set) tag = "R2";
        if (gbl_clr) tag = "R1";
        cyc();
      end
      gbl_set = 1'b0; gbl_clr = 1'b0;
    end
    finish_run();
  end

  initial begin
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end
endmodule